// File: doc/BRIEF.md
# Lock Status and Test-Clock Output Selector

This block drives one status pin. By default the pin shows whether the PLL is in lock. The lock flag comes from the phase-detector logic and is synchronised into the crystal clock domain. A 3-bit select field can instead send an internal clock to the same pin for test:

- the crystal clock, undivided;
- half the rate of the phase-detector pump-up pulse train;
- half the rate of the reference input clock;
- half the rate of the feedback clock that reaches the phase detector.

The select field is captured in a register on the crystal clock. Each halved clock comes from its own toggle flip-flop, clocked by its own source. A change of selection may leave one shortened pulse on the pin. Switching without glitches is not attempted.

Top module: `lock_test_out`

## Requirements
- R1: While the registered select has its top bit at 0 (codes 000, 001, 010 and 011), the pin equals the synchronised lock flag. The low two select bits have no effect in this mode.
- R2: A rise or fall of the lock flag, applied between crystal edges, reaches the pin on the SYNC_STAGES-th rising crystal edge after the change. The default is 2 stages.
- R3: With select 100 the pin carries the crystal clock at full rate.
- R4: With select 101 the pin toggles once per pump-up pulse, which is half the pulse rate.
- R5: With select 110 the pin carries the reference clock divided by 2, with a duty cycle near 50%.
- R6: With select 111 the pin carries the feedback clock divided by 2.
- R7: The select input takes effect only at a rising crystal edge. While reset is high, the select register holds 000, the synchroniser holds 0 and the pin is 0.
- R8: Out of reset, every divide-by-2 stage changes state on every rising edge of its own source clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal oscillator clock; clocks the select register and the lock synchroniser |
| rst | input | 1 | Synchronous active-high reset; must be held across several edges of every source clock |
| lock_in | input | 1 | PLL lock flag from the phase-detector logic |
| pump_up | input | 1 | Phase-detector pump-up pulse train |
| clk_ref | input | 1 | Reference input clock at the phase detector |
| clk_fb | input | 1 | Feedback clock at the phase detector |
| sel | input | 3 | Pin function select: 0xx lock, 100 crystal, 101 pump-up/2, 110 reference/2, 111 feedback/2 |
| pin_out | output | 1 | Status / test clock pin |

## Verification
The assertions assume four things about the inputs:
- reset is held high across at least one rising edge of every source clock, so each divider leaves reset in a known state;
- the lock flag changes away from crystal edges;
- the select field changes away from crystal edges;
- all four source clocks keep running.

The stimulus holds reset for many cycles of the slowest source. It drives the lock flag and the select field only at falling crystal edges. It lets all four clocks run freely at unrelated periods for the whole run. Frequency is measured only after a settling gap, so the shortened pulse that may follow a select change stays out of every count.

// File: rtl/lsto_pkg.sv
package lsto_pkg;
  localparam int SEL_W = 3;
  localparam int DIV_N = 3;

  // pin source selection codes (top bit 0 means lock status)
  localparam logic [SEL_W-1:0] SEL_LOCK = 3'b000;
  localparam logic [SEL_W-1:0] SEL_XTAL = 3'b100;
  localparam logic [SEL_W-1:0] SEL_PUMP = 3'b101;
  localparam logic [SEL_W-1:0] SEL_REF  = 3'b110;
  localparam logic [SEL_W-1:0] SEL_FB   = 3'b111;

  // index of each halved clock inside the divider vector
  localparam int DIV_PUMP = 0;
  localparam int DIV_REF  = 1;
  localparam int DIV_FB   = 2;
endpackage

// File: rtl/lsto_half_div.sv
module lsto_half_div (
  input  logic clk_src,
  input  logic rst,
  output logic half_q
);
  always_ff @(posedge clk_src) begin
    if (rst) half_q <= 1'b0;
    else     half_q <= ~half_q;
  end

  // R8: toggles on every source edge once out of reset
  a_r8_toggle_each_edge: assert property (@(posedge clk_src) disable iff (rst)
    1'b1 |=> (half_q != $past(half_q)));
endmodule

// File: rtl/lsto_sync.sv
module lsto_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

  // R2: the output only rises after the stage before it held a 1
  a_r2_rise_from_chain: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> $past(chain_q[STAGES-2]));
endmodule

// File: rtl/lsto_out_sel.sv
module lsto_out_sel
  import lsto_pkg::*;
#(
  parameter int N_DIV = DIV_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             lock_s,
  input  logic             xtal,
  input  logic [N_DIV-1:0] div_q,
  output logic             pin_out
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= SEL_LOCK;
    else     sel_q <= sel_in;
  end

  always_comb begin
    pin_out = lock_s;
    if (sel_q[SEL_W-1]) begin
      unique case (sel_q)
        SEL_XTAL: pin_out = xtal;
        SEL_PUMP: pin_out = div_q[DIV_PUMP];
        SEL_REF:  pin_out = div_q[DIV_REF];
        SEL_FB:   pin_out = div_q[DIV_FB];
        default:  pin_out = lock_s;
      endcase
    end
  end

  // R7: the select register takes the port value at each crystal edge
  a_r7_sel_capture: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sel_q == $past(sel_in)));

  // R1: lock mode shows the synchroniser output, checked mid-cycle
  a_r1_lock_follow: assert property (@(negedge clk) disable iff (rst)
    (sel_q[SEL_W-1] == 1'b0) |-> (pin_out == lock_s));
endmodule

// File: rtl/lock_test_out.sv
module lock_test_out
  import lsto_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_xtal,
  input  logic             rst,
  input  logic             lock_in,
  input  logic             pump_up,
  input  logic             clk_ref,
  input  logic             clk_fb,
  input  logic [SEL_W-1:0] sel,
  output logic             pin_out
);
  logic [DIV_N-1:0] div_src;
  logic [DIV_N-1:0] div_q;
  logic             lock_s;

  assign div_src[DIV_PUMP] = pump_up;
  assign div_src[DIV_REF]  = clk_ref;
  assign div_src[DIV_FB]   = clk_fb;

  for (genvar g = 0; g < DIV_N; g++) begin : g_div
    lsto_half_div u_div (
      .clk_src (div_src[g]),
      .rst     (rst),
      .half_q  (div_q[g])
    );
  end

  lsto_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk_xtal),
    .rst (rst),
    .d   (lock_in),
    .q   (lock_s)
  );

  lsto_out_sel #(.N_DIV(DIV_N)) u_sel (
    .clk     (clk_xtal),
    .rst     (rst),
    .sel_in  (sel),
    .lock_s  (lock_s),
    .xtal    (clk_xtal),
    .div_q   (div_q),
    .pin_out (pin_out)
  );
endmodule

// File: tb/lock_test_out_tb_top.sv
module lock_test_out_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REF_PERIOD = 14;
  localparam int FB_PERIOD  = 22;
  localparam int PUMP_GAP   = 24;
  localparam int PUMP_HIGH  = 6;
  localparam int WIN        = 1200;
  localparam int SETTLE     = 100;

  logic clk_xtal = 1'b0, clk_ref = 1'b0, clk_fb = 1'b0, pump_up = 1'b0;
  logic rst = 1'b1, lock_in = 1'b0;
  logic [2:0] sel = 3'b000;
  logic pin_out;

  int checks = 0;
  int errors = 0;
  int edge_cnt = 0;

  typedef struct {
    string tag;
    int    lo;
    int    hi;
    int    lvl;
    bit    duty;
  } exp_t;
  exp_t sb_q[$];

  lock_test_out dut_i (
    .clk_xtal (clk_xtal),
    .rst      (rst),
    .lock_in  (lock_in),
    .pump_up  (pump_up),
    .clk_ref  (clk_ref),
    .clk_fb   (clk_fb),
    .sel      (sel),
    .pin_out  (pin_out)
  );

  always #(CLK_PERIOD/2) clk_xtal = ~clk_xtal;
  always #(REF_PERIOD/2) clk_ref  = ~clk_ref;
  always #(FB_PERIOD/2)  clk_fb   = ~clk_fb;
  initial forever begin
    #PUMP_GAP  pump_up = 1'b1;
    #PUMP_HIGH pump_up = 1'b0;
  end

  always @(posedge pin_out) edge_cnt++;

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures the pin over a window and compares with the queue head
  initial forever begin
    exp_t it;
    int c0, highs, n;
    wait (sb_q.size() != 0);
    it = sb_q[0];
    c0 = edge_cnt;
    highs = 0;
    for (int t = 0; t < WIN; t++) begin
      #1;
      if (pin_out) highs++;
    end
    n = edge_cnt - c0;
    check({it.tag, " edges"}, (n >= it.lo) && (n <= it.hi), n, it.lo);
    if (it.lvl >= 0) check({it.tag, " level"}, int'(pin_out) == it.lvl, int'(pin_out), it.lvl);
    if (it.duty) check({it.tag, " duty%"}, (highs*100/WIN >= 40) && (highs*100/WIN <= 60),
                       highs*100/WIN, 50);
    void'(sb_q.pop_front());
  end

  // driver: set inputs off-edge, settle, push the expectation, wait for the monitor
  task automatic run_case(input logic [2:0] s, input logic lk, input string tag,
                          input int src_period, input int div, input bit duty);
    exp_t it;
    @(negedge clk_xtal);
    sel = s;
    lock_in = lk;
    #SETTLE;
    it.tag = tag;
    it.duty = duty;
    if (src_period == 0) begin
      it.lo = 0; it.hi = 0; it.lvl = int'(lk);
    end else begin
      it.lo = WIN / (src_period*div) - 1;
      it.hi = WIN / (src_period*div) + 1;
      it.lvl = -1;
    end
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  initial begin
    #(CLK_PERIOD*20);
    check("R7 reset pin low", pin_out == 1'b0, int'(pin_out), 0);
    @(negedge clk_xtal);
    sel = 3'b100;
    lock_in = 1'b1;
    repeat (3) @(negedge clk_xtal);
    check("R7 reset holds pin low", pin_out == 1'b0, int'(pin_out), 0);
    sel = 3'b000;
    lock_in = 1'b0;
    @(negedge clk_xtal);
    rst = 1'b0;
    repeat (4) @(negedge clk_xtal);

    // R2: latency of a lock rise and fall
    lock_in = 1'b1;
    @(negedge clk_xtal);
    check("R2 rise not yet after 1 edge", pin_out == 1'b0, int'(pin_out), 0);
    @(negedge clk_xtal);
    check("R2 rise after 2 edges", pin_out == 1'b1, int'(pin_out), 1);
    lock_in = 1'b0;
    @(negedge clk_xtal);
    check("R2 fall not yet after 1 edge", pin_out == 1'b1, int'(pin_out), 1);
    @(negedge clk_xtal);
    check("R2 fall after 2 edges", pin_out == 1'b0, int'(pin_out), 0);

    // R1: all four lock-mode codes, both lock levels
    for (int c = 0; c < 4; c++) begin
      run_case(3'(c), 1'b1, $sformatf("R1 code %0d locked", c), 0, 1, 1'b0);
      run_case(3'(c), 1'b0, $sformatf("R1 code %0d unlocked", c), 0, 1, 1'b0);
    end

    run_case(3'b100, 1'b0, "R3 xtal", CLK_PERIOD, 1, 1'b1);
    run_case(3'b101, 1'b1, "R4 pump/2", PUMP_GAP + PUMP_HIGH, 2, 1'b1);
    run_case(3'b110, 1'b0, "R5 ref/2", REF_PERIOD, 2, 1'b1);
    run_case(3'b111, 1'b1, "R6 fb/2", FB_PERIOD, 2, 1'b1);
    run_case(3'b110, 1'b1, "R8 ref/2 again", REF_PERIOD, 2, 1'b0);

    // R7: select takes effect only at a crystal edge
    @(negedge clk_xtal);
    sel = 3'b000;
    lock_in = 1'b0;
    repeat (4) @(negedge clk_xtal);
    sel = 3'b100;
    #1;
    check("R7 select not yet applied", pin_out == 1'b0, int'(pin_out), 0);
    @(posedge clk_xtal);
    #1;
    check("R7 select applied at edge", pin_out == 1'b1, int'(pin_out), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule